// File: doc/BRIEF.md
# Limb-Serial Carrying Multiply-Accumulate Unit

This unit multiplies one unsigned 64-bit scalar by a multi-word unsigned integer. The integer arrives as a stream of 64-bit limbs, least significant limb first. Each step forms scalar times limb plus a running carry as an exact 128-bit value. The low half of that value leaves the unit as the next product limb. The high half goes back into a single carry register, and that register is the addend of the following step.

A caller pulses `start` with the scalar and a limb count from 1 to `MAX_LIMBS`. It then offers limbs on a valid/ready handshake. The unit returns count+1 product limbs, one per `out_valid` strobe, and the last of these is the final carry. A 4-limb (256-bit) operand therefore yields a 320-bit product. The multiplier is either purely combinational or a pipeline of fixed depth. Because each step needs the carry of the step before it, the unit holds off the next limb until the previous high half is back.

Top module: `limb_mac_serial`

## Requirements
- R1: A `start` pulse seen while idle, with `len` between 1 and `MAX_LIMBS`, loads the scalar and the count and zeroes the carry. `busy` is high in the next cycle, and `limb_ready` is high in that same cycle.
- R2: A `start` pulse whose `len` is 0 or greater than `MAX_LIMBS` is ignored. `busy` stays low and no output limb appears.
- R3: A `start` pulse that arrives while `busy` is high is ignored. The running product keeps its original scalar and count.
- R4: For step i (i counts from 0), the output limb is bits 63:0 of scalar × limb_i + carry. Output limbs leave in ascending significance order.
- R5: Bits 127:64 of each step's result become the carry, and that carry is the addend of the next step.
- R6: The count+1-th output limb is the final carry, and `out_last` is high with it. Each operation produces exactly count+1 `out_valid` strobes.
- R7: `limb_ready` is high only while busy, with no step in flight and limbs still owed. When `MUL_LAT` is above 0, it is low in the cycle after a limb is accepted.
- R8: The product limb for a limb accepted in cycle c is presented with `out_valid` in cycle c+MUL_LAT+1. The top limb follows one cycle after the last low limb.
- R9: `busy` falls in the same cycle that the top limb is presented with `out_last`.
- R10: `limb_valid` asserted while `limb_ready` is low is ignored. It produces no output and does not change later product limbs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin an operation (one-cycle pulse) |
| len | input | CNT_W | Number of input limbs, 1..MAX_LIMBS |
| scalar | input | LIMB_W | Scalar multiplier, sampled on an accepted start |
| limb_valid | input | 1 | An input limb is offered |
| limb_data | input | LIMB_W | Input limb, least significant first |
| limb_ready | output | 1 | The unit takes the offered limb this cycle |
| busy | output | 1 | An operation is in progress |
| out_valid | output | 1 | A product limb is presented |
| out_data | output | LIMB_W | Product limb |
| out_last | output | 1 | The presented limb is the final carry (top limb) |

## Verification
A low product limb is due exactly MUL_LAT+1 cycles after the cycle in which its input limb was accepted. The top carry limb is due one cycle after that, and `busy` drops with it. The driver records the accept cycle of every limb it hands over. It pushes the expected limb, its last flag and its due cycle into a queue. The monitor pops one entry on every `out_valid` strobe and compares the data, the flag and the cycle count. The expected limbs are sliced out of a single wide product computed in the bench. Stray `start` or `limb_valid` activity must add no strobe, since any output that arrives with nothing queued counts as a failure.

// File: rtl/lmac_pkg.sv
package lmac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_TAIL = 2'd2
  } lmac_state_e;
endpackage

// File: rtl/lmac_rst_sync.sv
module lmac_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/lmac_seq.sv
module lmac_seq
  import lmac_pkg::*;
#(
  parameter int LIMB_W    = 64,
  parameter int MAX_LIMBS = 8,
  parameter int CNT_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic [LIMB_W-1:0] scalar,
  input  logic              limb_valid,
  input  logic              res_vld,
  output logic              limb_ready,
  output logic              issue,
  output logic              clear_carry,
  output logic              tail_go,
  output logic              busy,
  output logic [LIMB_W-1:0] scalar_q
);
  lmac_state_e      state_q, state_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic [CNT_W-1:0] issued_q, issued_d;
  logic [CNT_W-1:0] done_q, done_d;
  logic             pending_q, pending_d;
  logic             start_ok;
  logic             last_res;

  // accept a start only when idle and the count is in range
  assign start_ok = (state_q == ST_IDLE) && start &&
                    (len != '0) && (len <= CNT_W'(MAX_LIMBS));
  assign limb_ready = (state_q == ST_RUN) && !pending_q && (issued_q != len_q);
  assign issue      = limb_ready && limb_valid;
  assign last_res   = res_vld && (done_q == (len_q - CNT_W'(1)));
  assign clear_carry = start_ok;
  assign tail_go    = (state_q == ST_TAIL);
  assign busy       = (state_q != ST_IDLE);

  always_comb begin
    state_d   = state_q;
    len_d     = len_q;
    issued_d  = issued_q;
    done_d    = done_q;
    pending_d = (pending_q | issue) & ~res_vld;
    case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d   = ST_RUN;
          len_d     = len;
          issued_d  = '0;
          done_d    = '0;
          pending_d = 1'b0;
        end
      end
      ST_RUN: begin
        if (issue)   issued_d = issued_q + CNT_W'(1);
        if (res_vld) done_d   = done_q + CNT_W'(1);
        if (last_res) state_d = ST_TAIL;
      end
      ST_TAIL: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      len_q     <= '0;
      issued_q  <= '0;
      done_q    <= '0;
      pending_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      len_q     <= len_d;
      issued_q  <= issued_d;
      done_q    <= done_d;
      pending_q <= pending_d;
    end
  end

  // operand hold register, enabled only by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scalar_q <= '0;
    else if (start_ok) scalar_q <= scalar;
  end
endmodule

// File: rtl/lmac_mul.sv
module lmac_mul #(
  parameter int LIMB_W = 64,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [LIMB_W-1:0] op_a,
  input  logic [LIMB_W-1:0] op_b,
  input  logic [LIMB_W-1:0] op_c,
  output logic              res_vld,
  output logic [LIMB_W-1:0] res_lo,
  output logic [LIMB_W-1:0] res_hi
);
  localparam int RES_W = 2 * LIMB_W;

  logic [RES_W-1:0] full;

  // exact: (2^W-1)^2 + (2^W-1) < 2^(2W)
  assign full = ({{LIMB_W{1'b0}}, op_a} * {{LIMB_W{1'b0}}, op_b}) +
                {{LIMB_W{1'b0}}, op_c};

  generate
    if (LAT == 0) begin : g_comb
      assign res_vld = in_vld;
      assign res_lo  = full[LIMB_W-1:0];
      assign res_hi  = full[RES_W-1:LIMB_W];
    end else begin : g_pipe
      logic [LAT-1:0]   vld_q;
      logic [RES_W-1:0] dat_q [LAT];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q[0] <= 1'b0;
        else        vld_q[0] <= in_vld;
      end
      always_ff @(posedge clk) begin
        if (in_vld) dat_q[0] <= full;
      end

      for (genvar s = 1; s < LAT; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) vld_q[s] <= 1'b0;
          else        vld_q[s] <= vld_q[s-1];
        end
        always_ff @(posedge clk) begin
          if (vld_q[s-1]) dat_q[s] <= dat_q[s-1];
        end
      end

      assign res_vld = vld_q[LAT-1];
      assign res_lo  = dat_q[LAT-1][LIMB_W-1:0];
      assign res_hi  = dat_q[LAT-1][RES_W-1:LIMB_W];
    end
  endgenerate
endmodule

// File: rtl/lmac_acc.sv
module lmac_acc #(
  parameter int LIMB_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_carry,
  input  logic              res_vld,
  input  logic [LIMB_W-1:0] res_lo,
  input  logic [LIMB_W-1:0] res_hi,
  input  logic              tail_go,
  output logic [LIMB_W-1:0] carry_q,
  output logic              out_valid,
  output logic              out_data_last,
  output logic [LIMB_W-1:0] out_data
);
  logic [LIMB_W-1:0] carry_d;
  logic              carry_en;
  logic              out_en;
  logic [LIMB_W-1:0] out_d;

  always_comb begin
    carry_en = clear_carry | res_vld;
    carry_d  = clear_carry ? '0 : res_hi;
    out_en   = res_vld | tail_go;
    out_d    = tail_go ? carry_q : res_lo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        carry_q <= '0;
    else if (carry_en) carry_q <= carry_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_data_last <= 1'b0;
    end else begin
      out_valid     <= out_en;
      out_data_last <= tail_go;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_data <= '0;
    else if (out_en) out_data <= out_d;
  end
endmodule

// File: rtl/limb_mac_serial.sv
module limb_mac_serial #(
  parameter int LIMB_W    = 64,
  parameter int MAX_LIMBS = 8,
  parameter int MUL_LAT   = 2,
  localparam int CNT_W    = $clog2(MAX_LIMBS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic [LIMB_W-1:0] scalar,
  input  logic              limb_valid,
  input  logic [LIMB_W-1:0] limb_data,
  output logic              limb_ready,
  output logic              busy,
  output logic              out_valid,
  output logic [LIMB_W-1:0] out_data,
  output logic              out_last
);
  logic              rst_n_i;
  logic              issue;
  logic              clear_carry;
  logic              tail_go;
  logic              res_vld;
  logic [LIMB_W-1:0] res_lo, res_hi;
  logic [LIMB_W-1:0] scalar_q;
  logic [LIMB_W-1:0] carry_q;

  lmac_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_i)
  );

  lmac_seq #(.LIMB_W(LIMB_W), .MAX_LIMBS(MAX_LIMBS), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .start       (start),
    .len         (len),
    .scalar      (scalar),
    .limb_valid  (limb_valid),
    .res_vld     (res_vld),
    .limb_ready  (limb_ready),
    .issue       (issue),
    .clear_carry (clear_carry),
    .tail_go     (tail_go),
    .busy        (busy),
    .scalar_q    (scalar_q)
  );

  lmac_mul #(.LIMB_W(LIMB_W), .LAT(MUL_LAT)) u_mul (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .in_vld  (issue),
    .op_a    (scalar_q),
    .op_b    (limb_data),
    .op_c    (carry_q),
    .res_vld (res_vld),
    .res_lo  (res_lo),
    .res_hi  (res_hi)
  );

  lmac_acc #(.LIMB_W(LIMB_W)) u_acc (
    .clk           (clk),
    .rst_n         (rst_n_i),
    .clear_carry   (clear_carry),
    .res_vld       (res_vld),
    .res_lo        (res_lo),
    .res_hi        (res_hi),
    .tail_go       (tail_go),
    .carry_q       (carry_q),
    .out_valid     (out_valid),
    .out_data_last (out_last),
    .out_data      (out_data)
  );
endmodule

// File: rtl/lmac_chk.sv
module lmac_chk #(
  parameter int MAX_LIMBS = 8,
  parameter int MUL_LAT   = 2,
  parameter int CNT_W     = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] len,
  input logic             limb_valid,
  input logic             limb_ready,
  input logic             busy,
  input logic             out_valid,
  input logic             out_last
);
  logic [MUL_LAT:0] acc_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_hist <= '0;
    else begin
      for (int i = MUL_LAT; i > 0; i--) acc_hist[i] <= acc_hist[i-1];
      acc_hist[0] <= limb_valid && limb_ready;
    end
  end

  // R7
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limb_ready |-> busy);

  generate
    if (MUL_LAT > 0) begin : g_gap
      // R7
      ready_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (limb_valid && limb_ready) |=> !limb_ready);
    end
  endgenerate

  // R8
  limb_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hist[MUL_LAT] |-> (out_valid && !out_last));

  // R8
  no_stray_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> acc_hist[MUL_LAT]);

  // R6
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  // R9
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_last);

  // R9
  last_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> !busy);

  // R2
  bad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && ((len == '0) || (len > CNT_W'(MAX_LIMBS)))) |=> !busy);
endmodule

bind limb_mac_serial lmac_chk #(.MAX_LIMBS(MAX_LIMBS), .MUL_LAT(MUL_LAT), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .len        (len),
  .limb_valid (limb_valid),
  .limb_ready (limb_ready),
  .busy       (busy),
  .out_valid  (out_valid),
  .out_last   (out_last)
);

// File: tb/sim_limb_mac_serial.sv
`timescale 1ns/1ps
module sim_limb_mac_serial;
  localparam int W   = 64;
  localparam int MAXL = 8;
  localparam int LAT = 2;
  localparam int CW  = $clog2(MAXL + 1);

  logic          clk, rst_n, start, limb_valid;
  logic [CW-1:0] len;
  logic [W-1:0]  scalar, limb_data;
  logic          limb_ready, busy, out_valid, out_last;
  logic [W-1:0]  out_data;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  typedef struct {
    logic [W-1:0] d;
    logic         l;
    int           due;
    string        tag;
  } exp_t;
  exp_t q[$];

  limb_mac_serial #(.LIMB_W(W), .MAX_LIMBS(MAXL), .MUL_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .scalar(scalar),
    .limb_valid(limb_valid), .limb_data(limb_data), .limb_ready(limb_ready),
    .busy(busy), .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  initial clk = 0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp, string what);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !done) begin
      if (q.size() == 0) begin
        chk("R10", 1, 0, "unexpected output limb");
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(e.tag, out_data, e.d, "product limb");
        chk("R6", out_last, e.l, "last flag");
        chk("R8", cyc, e.due, "due cycle");
        if (e.l) chk("R9", busy, 0, "busy with top limb");
      end
    end
  end

  // driver: runs one operation, optional stray start after first accept (R3)
  task automatic run_op(logic [W-1:0] s, logic [W-1:0] lb [MAXL], int n,
                        string tag, bit mid_start);
    logic [W*(MAXL+1)-1:0] prod;
    logic [W*MAXL-1:0]     big;
    int due;
    big = '0;
    for (int i = 0; i < n; i++) big[i*W +: W] = lb[i];
    prod = (W*(MAXL+1))'(s) * (W*(MAXL+1))'(big);
    start = 1; len = CW'(n); scalar = s;
    @(negedge clk);
    start = 0; len = '0; scalar = '0;
    // R1
    chk("R1", {busy, limb_ready}, 2'b11, "busy and ready after start");
    due = 0;
    for (int i = 0; i < n; i++) begin
      limb_valid = 1; limb_data = lb[i];
      while (!limb_ready) @(negedge clk);
      due = cyc + LAT + 1;
      q.push_back('{d: prod[i*W +: W], l: 1'b0, due: due, tag: tag});
      @(negedge clk);
      limb_valid = 0; limb_data = '1;
      if (mid_start && i == 0) begin
        start = 1; len = CW'(1); scalar = ~s;
        @(negedge clk);
        start = 0;
      end
    end
    q.push_back('{d: prod[n*W +: W], l: 1'b1, due: due + 1, tag: "R6"});
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R9", busy, 0, "idle after op");
  endtask

  logic [W-1:0] lb [MAXL];

  initial begin
    rst_n = 0; start = 0; len = '0; scalar = '0; limb_valid = 0; limb_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", {busy, out_valid, limb_ready}, 3'b000, "reset state");
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R2: out-of-range counts
    start = 1; len = '0; scalar = 64'h5;
    @(negedge clk); start = 0;
    chk("R2", {busy, limb_ready}, 2'b00, "len 0 ignored");
    start = 1; len = CW'(MAXL + 1);
    @(negedge clk); start = 0;
    chk("R2", {busy, limb_ready}, 2'b00, "len above max ignored");
    repeat (5) @(negedge clk);

    // R5: all-ones operands, every step produces a carry
    for (int i = 0; i < MAXL; i++) lb[i] = '1;
    run_op('1, lb, 4, "R5", 0);
    run_op('1, lb, MAXL, "R5", 0);

    // R4: single limb, zero scalar, small values
    lb[0] = 64'h1234_5678_9abc_def0;
    run_op(64'h3, lb, 1, "R4", 0);
    run_op('0, lb, 1, "R4", 0);

    // R10: stray valid while idle
    limb_valid = 1; limb_data = 64'hdead_beef;
    repeat (3) begin
      @(negedge clk);
      chk("R10", {out_valid, limb_ready}, 2'b00, "stray limb while idle");
    end
    limb_valid = 0;

    // R3: stray start during an operation
    for (int i = 0; i < MAXL; i++) lb[i] = {$urandom, $urandom};
    run_op({$urandom, $urandom}, lb, 5, "R3", 1);

    // R4: random operands and lengths
    for (int t = 0; t < 12; t++) begin
      for (int i = 0; i < MAXL; i++) lb[i] = {$urandom, $urandom};
      run_op({$urandom, $urandom}, lb, 1 + (t % MAXL), "R4", 0);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule